// File: doc/BRIEF.md
# Memory-Format Instruction Executor

This block carries out the memory-access instructions of a small 16-bit processor. It holds its own register bank of eight 16-bit registers and a 256-word, 16-bit data memory. When `instValid` is high, the block decodes `instWord` and then acts in one of two ways. It fetches an address from one register and loads the addressed word into a second register, or it writes that second register into the addressed word. The block raises `done` to acknowledge every instruction it accepts.

A store finishes in the cycle the instruction is presented. A load spends one extra cycle, because the memory read is registered. A word that is not a valid memory-format instruction is flagged on `illegal` and leaves all state unchanged. A debug write port lets the environment preload registers and memory words. A combinational peek port reads any register back.

Top module: `lsu_top`

## Requirements
- R1: After reset every register reads 0 through the peek port, and `done` and `illegal` are low while no instruction is presented.
- R2: A word is a memory instruction only when bits 1:0 equal 2'b11 and bits 9:3 are all zero. Any other word presented with `instValid` raises `illegal` and `done` in that cycle and changes no register and no memory word.
- R3: A store has bit 2 = 1. It writes register rx (bits 15:13) to the memory word addressed by register ry (bits 12:10) at the end of the valid cycle, with `done` high in that cycle.
- R4: A load has bit 2 = 0. It raises `done` only in the cycle after the valid cycle, for exactly one cycle. Register rx reads the loaded word from the cycle after that.
- R5: Only the low 8 bits of register ry form the address, and its upper bits are ignored. Addresses 0x00 through 0xFF are all reachable.
- R6: When rx equals ry, a store writes the address value itself, and a load replaces the address register with the loaded word.
- R7: When `dbgWe` is high, the debug port writes `dbgData` at the next edge. The write goes to memory word `dbgAddr` when `dbgToMem` is 1, and to register `dbgAddr[2:0]` when `dbgToMem` is 0.
- R8: `peekData` shows register `peekSel` combinationally.
- R9: An instruction presented during the cycle in which a load raises `done` is ignored, and no memory or register write results from it.
- R10: A load issued in the cycle right after a store to the same address returns the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Instruction word present |
| instWord | input | 16 | Instruction word |
| done | output | 1 | Instruction acknowledged / completed |
| illegal | output | 1 | Presented word is not a legal memory instruction |
| dbgWe | input | 1 | Debug write enable |
| dbgToMem | input | 1 | Debug target: 1 memory, 0 register |
| dbgAddr | input | 8 | Debug address (register index in low 3 bits) |
| dbgData | input | 16 | Debug write data |
| peekSel | input | 3 | Register to observe |
| peekData | output | 16 | Value of the selected register |

## Verification
The bench uses the default parameters: 16-bit data and a 256-word memory. With these values the full 8-bit address space is reachable, including word 0xFF, reached from a register whose upper byte is non-zero. Because the register fields are three bits wide, the defaults also make the case where rx and ry name the same register reachable. The bench places a load in the cycle straight after a store and offers a second instruction in a load's completion cycle, so both timing corners are exercised.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int INSN_W   = 16;
  localparam int RIDX_W   = 3;
  localparam int REG_CNT  = 1 << RIDX_W;
  localparam int RX_LSB   = 13;
  localparam int RY_LSB   = 10;
  localparam int RES_MSB  = 9;
  localparam int RES_LSB  = 3;
  localparam int OP_BIT   = 2;
  localparam logic [1:0] MEM_TAG = 2'b11;

  typedef enum logic {
    ST_IDLE,
    ST_LOADWB
  } lsuState_t;

  typedef struct packed {
    logic              memWr;
    logic              memRd;
    logic              regWr;
    logic [RIDX_W-1:0] rxSel;
    logic [RIDX_W-1:0] rySel;
  } lsuStrobe_t;
endpackage

// File: rtl/lsu_ctrl.sv
module lsu_ctrl
  import lsu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [INSN_W-1:0] instWord,
  output lsuStrobe_t        stb,
  output logic              done,
  output logic              illegal
);
  lsuState_t         state;
  logic [RIDX_W-1:0] pendRx;
  logic [RIDX_W-1:0] rxField;
  logic [RIDX_W-1:0] ryField;
  logic              isMem;
  logic              isStore;
  logic              accept;
  logic              loadStart;

  assign rxField = instWord[RX_LSB +: RIDX_W];
  assign ryField = instWord[RY_LSB +: RIDX_W];
  assign isMem   = (instWord[1:0] == MEM_TAG) && (instWord[RES_MSB:RES_LSB] == '0);
  assign isStore = instWord[OP_BIT];
  assign accept  = (state == ST_IDLE) && instValid;
  assign loadStart = accept && isMem && !isStore;

  always_comb begin
    stb       = '0;
    stb.rxSel = rxField;
    stb.rySel = ryField;
    if (state == ST_LOADWB) begin
      stb.regWr = 1'b1;
      stb.rxSel = pendRx;
    end else if (accept && isMem) begin
      if (isStore) stb.memWr = 1'b1;
      else         stb.memRd = 1'b1;
    end
  end

  assign illegal = accept && !isMem;
  assign done    = (state == ST_LOADWB) || (accept && (!isMem || isStore));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      pendRx <= '0;
    end else begin
      if (loadStart) begin
        state  <= ST_LOADWB;
        pendRx <= rxField;
      end else begin
        state  <= ST_IDLE;
      end
    end
  end

  // R4
  load_done_next_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadStart |=> (done && stb.regWr && !illegal));

  // R4
  wb_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOADWB) |=> (state == ST_IDLE));

  // R9
  wb_no_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOADWB) |-> (!stb.memWr && !stb.memRd && !illegal));

  // R2
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (done && !stb.memWr && !stb.memRd && !stb.regWr));
endmodule

// File: rtl/lsu_datapath.sv
module lsu_datapath
  import lsu_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int MEM_DEPTH = 256,
  localparam int ADDR_W   = $clog2(MEM_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  lsuStrobe_t        stb,
  input  logic              dbgWe,
  input  logic              dbgToMem,
  input  logic [ADDR_W-1:0] dbgAddr,
  input  logic [DATA_W-1:0] dbgData,
  input  logic [RIDX_W-1:0] peekSel,
  output logic [DATA_W-1:0] peekData
);
  logic [DATA_W-1:0] regs [REG_CNT];
  logic [DATA_W-1:0] mem  [MEM_DEPTH];
  logic [DATA_W-1:0] rdData;
  logic [DATA_W-1:0] ryVal;
  logic [DATA_W-1:0] rxVal;
  logic [ADDR_W-1:0] addr;

  assign ryVal    = regs[stb.rySel];
  assign rxVal    = regs[stb.rxSel];
  assign addr     = ryVal[ADDR_W-1:0];
  assign peekData = regs[peekSel];

  always_ff @(posedge clk) begin
    if (stb.memWr)
      mem[addr] <= rxVal;
    else if (dbgWe && dbgToMem)
      mem[dbgAddr] <= dbgData;
    if (stb.memRd)
      rdData <= mem[addr];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < REG_CNT; i++) regs[i] <= '0;
    end else if (stb.regWr) begin
      regs[stb.rxSel] <= rdData;
    end else if (dbgWe && !dbgToMem) begin
      regs[dbgAddr[RIDX_W-1:0]] <= dbgData;
    end
  end

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.memWr, stb.memRd, stb.regWr}));

  // R3
  store_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.memWr |=> (mem[$past(addr)] == $past(rxVal)));

  // R4
  load_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.regWr |=> (regs[$past(stb.rxSel)] == $past(rdData)));
endmodule

// File: rtl/lsu_top.sv
module lsu_top
  import lsu_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int MEM_DEPTH = 256,
  localparam int ADDR_W   = $clog2(MEM_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [INSN_W-1:0] instWord,
  output logic              done,
  output logic              illegal,
  input  logic              dbgWe,
  input  logic              dbgToMem,
  input  logic [ADDR_W-1:0] dbgAddr,
  input  logic [DATA_W-1:0] dbgData,
  input  logic [RIDX_W-1:0] peekSel,
  output logic [DATA_W-1:0] peekData
);
  lsuStrobe_t stb;

  lsu_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .instValid (instValid),
    .instWord  (instWord),
    .stb       (stb),
    .done      (done),
    .illegal   (illegal)
  );

  lsu_datapath #(
    .DATA_W    (DATA_W),
    .MEM_DEPTH (MEM_DEPTH)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .dbgWe    (dbgWe),
    .dbgToMem (dbgToMem),
    .dbgAddr  (dbgAddr),
    .dbgData  (dbgData),
    .peekSel  (peekSel),
    .peekData (peekData)
  );
endmodule

// File: tb/test_lsu_top.sv
`timescale 1ns/1ps
module test_lsu_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic [15:0] instWord = '0;
  logic        done, illegal;
  logic        dbgWe = 1'b0, dbgToMem = 1'b0;
  logic [7:0]  dbgAddr = '0;
  logic [15:0] dbgData = '0;
  logic [2:0]  peekSel = '0;
  logic [15:0] peekData;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  lsu_top i_lsu_top (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instWord(instWord),
    .done(done), .illegal(illegal), .dbgWe(dbgWe), .dbgToMem(dbgToMem),
    .dbgAddr(dbgAddr), .dbgData(dbgData), .peekSel(peekSel), .peekData(peekData)
  );

  function automatic logic [15:0] enc(input logic [2:0] rx, input logic [2:0] ry, input logic st);
    return {rx, ry, 7'b0, st, 2'b11};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic dbgWrite(input logic toMem, input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    dbgWe = 1'b1; dbgToMem = toMem; dbgAddr = a; dbgData = d;
    @(negedge clk);
    dbgWe = 1'b0;
  endtask

  task automatic peek(input string req, input logic [2:0] r, input logic [15:0] exp);
    @(negedge clk);
    peekSel = r;
    #1 chk(req, peekData, exp);
  endtask

  task automatic doStore(input string req, input logic [2:0] rx, input logic [2:0] ry);
    @(negedge clk);
    instValid = 1'b1; instWord = enc(rx, ry, 1'b1);
    #1 chk({req, " store done"}, {15'b0, done}, 16'd1);
    chk({req, " store illegal"}, {15'b0, illegal}, 16'd0);
    @(negedge clk);
    instValid = 1'b0;
  endtask

  task automatic doLoad(input string req, input logic [2:0] rx, input logic [2:0] ry);
    @(negedge clk);
    instValid = 1'b1; instWord = enc(rx, ry, 1'b0);
    #1 chk({req, " load done early"}, {15'b0, done}, 16'd0);
    @(negedge clk);
    instValid = 1'b0;
    #1 chk({req, " load done"}, {15'b0, done}, 16'd1);
    @(negedge clk);
    #1 chk({req, " load done single"}, {15'b0, done}, 16'd0);
  endtask

  task automatic testReset();
    for (int i = 0; i < 8; i++) peek("R1 reg reset", 3'(i), 16'h0000);
    chk("R1 done idle", {15'b0, done}, 16'd0);
    chk("R1 illegal idle", {15'b0, illegal}, 16'd0);
  endtask

  task automatic testStoreLoad();
    dbgWrite(1'b0, 8'd1, 16'h0010);
    dbgWrite(1'b0, 8'd2, 16'hBEEF);
    peek("R7 R8 reg debug write", 3'd2, 16'hBEEF);
    doStore("R3", 3'd2, 3'd1);
    doLoad("R4", 3'd3, 3'd1);
    peek("R3 R4 load value", 3'd3, 16'hBEEF);
  endtask

  task automatic testDebugMem();
    dbgWrite(1'b1, 8'h33, 16'h1234);
    dbgWrite(1'b0, 8'd4, 16'h0033);
    doLoad("R7", 3'd5, 3'd4);
    peek("R7 mem debug write", 3'd5, 16'h1234);
  endtask

  task automatic testHighBits();
    dbgWrite(1'b0, 8'd6, 16'hAB33);
    doLoad("R5", 3'd7, 3'd6);
    peek("R5 upper ry bits ignored", 3'd7, 16'h1234);
    dbgWrite(1'b0, 8'd6, 16'h12FF);
    dbgWrite(1'b0, 8'd7, 16'h5A5A);
    doStore("R5 top", 3'd7, 3'd6);
    dbgWrite(1'b0, 8'd6, 16'h00FF);
    doLoad("R5 top", 3'd0, 3'd6);
    peek("R5 word 0xFF", 3'd0, 16'h5A5A);
  endtask

  task automatic testAlias();
    dbgWrite(1'b1, 8'h41, 16'h7777);
    dbgWrite(1'b0, 8'd1, 16'h0041);
    doLoad("R6 load alias", 3'd1, 3'd1);
    peek("R6 load alias", 3'd1, 16'h7777);
    dbgWrite(1'b0, 8'd2, 16'h0050);
    doStore("R6 store alias", 3'd2, 3'd2);
    doLoad("R6 store alias", 3'd3, 3'd2);
    peek("R6 store alias", 3'd3, 16'h0050);
  endtask

  task automatic testIllegal();
    dbgWrite(1'b1, 8'h60, 16'h1111);
    dbgWrite(1'b0, 8'd1, 16'h0060);
    dbgWrite(1'b0, 8'd2, 16'h2222);
    @(negedge clk);
    instValid = 1'b1; instWord = enc(3'd2, 3'd1, 1'b1) | 16'h0008;
    #1 chk("R2 reserved illegal", {15'b0, illegal}, 16'd1);
    chk("R2 reserved done", {15'b0, done}, 16'd1);
    @(negedge clk);
    instWord = {3'd3, 3'd1, 7'b0, 1'b0, 2'b10};
    #1 chk("R2 tag illegal", {15'b0, illegal}, 16'd1);
    @(negedge clk);
    instValid = 1'b0;
    #1 chk("R2 no done after", {15'b0, done}, 16'd0);
    peek("R2 rx untouched", 3'd3, 16'h0050);
    doLoad("R2 mem untouched", 3'd4, 3'd1);
    peek("R2 mem untouched", 3'd4, 16'h1111);
  endtask

  task automatic testIgnoreInWb();
    dbgWrite(1'b1, 8'h70, 16'h3333);
    dbgWrite(1'b0, 8'd1, 16'h0070);
    dbgWrite(1'b0, 8'd2, 16'h9999);
    @(negedge clk);
    instValid = 1'b1; instWord = enc(3'd3, 3'd1, 1'b0);
    @(negedge clk);
    instWord = enc(3'd2, 3'd1, 1'b1);
    #1 chk("R9 done in wb", {15'b0, done}, 16'd1);
    chk("R9 no illegal in wb", {15'b0, illegal}, 16'd0);
    @(negedge clk);
    instValid = 1'b0;
    doLoad("R9", 3'd4, 3'd1);
    peek("R9 store ignored", 3'd4, 16'h3333);
  endtask

  task automatic testBackToBack();
    dbgWrite(1'b0, 8'd1, 16'h0090);
    dbgWrite(1'b0, 8'd2, 16'hC0DE);
    @(negedge clk);
    instValid = 1'b1; instWord = enc(3'd2, 3'd1, 1'b1);
    #1 chk("R10 store done", {15'b0, done}, 16'd1);
    @(negedge clk);
    instWord = enc(3'd5, 3'd1, 1'b0);
    #1 chk("R10 load done early", {15'b0, done}, 16'd0);
    @(negedge clk);
    instValid = 1'b0;
    #1 chk("R10 load done", {15'b0, done}, 16'd1);
    peek("R10 forwarded value", 3'd5, 16'hC0DE);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testStoreLoad();
    testDebugMem();
    testHighBits();
    testAlias();
    testIllegal();
    testIgnoreInWb();
    testBackToBack();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule